// File: doc/BRIEF.md
# Transmit Robbed-Bit Signaling Inserter

This block sits in the transmit path of a 24-channel T1 stream and overwrites the least significant bit of each channel in the signaling frames with per-channel signaling bits. The signaling values come from a bank of 4-bit nibbles, one nibble per channel, that the host writes through a simple write port. The block does not send the bank directly. It copies the bank into a holding register once per 24-frame (3 ms) interval and sends only the holding register. After each copy it raises a one-cycle update pulse. The host then has until the next copy to rewrite any nibble.

The block works with extended-superframe (24-frame multiframe) and with D4 (12-frame multiframe) framing. In extended-superframe mode the four nibble bits go out in frames 6, 12, 18 and 24. In D4 mode a multiframe has room for only two bits per channel. So the nibble spans two consecutive multiframes: the upper pair goes out first, and the lower pair follows as the first pair of the next multiframe. The bank is therefore copied only on every other D4 multiframe.

The upstream framer gives the block the position of each serial bit: a valid strobe, a framing-bit marker, a frame number, a channel index and a bit index. The block returns the bit one cycle later, either unchanged or replaced by a signaling bit.

Top module: `rbs_tx_inserter`

## Requirements
- R1: In extended-superframe mode (`esf_mode_i`=1), bit index 7 (the channel's LSB) of channels 0..23 in frames 6, 12, 18 and 24 is replaced by held-nibble bit 3, 2, 1 and 0, respectively.
- R2: Every other valid bit, including the framing bit, leaves on `ser_o` unchanged one cycle after it enters. `vld_o` follows `bit_vld_i` with one cycle of delay. `ser_o` is 0 in cycles that carry no valid bit.
- R3: In D4 mode only frames 6 and 12 are robbed. In the multiframe that starts with a load they carry held-nibble bits 3 and 2. In the following multiframe they carry bits 1 and 0.
- R4: A load is the valid framing-bit slot of frame 1. In extended-superframe mode every multiframe start loads. In D4 mode every other multiframe start loads, and the first D4 multiframe after reset or after leaving extended-superframe mode loads.
- R5: `upd_irq_o` is a one-cycle pulse in the cycle after each load, and it is low at all other times.
- R6: The holding register changes only at a load. Bank writes between loads do not reach the stream until the next load.
- R7: A write in the same cycle as a load is not part of that load. Each write replaces a whole nibble, so the stream never carries a partly updated nibble.
- R8: Writes to a channel index of 24 or higher are ignored.
- R9: A synchronous active-high reset clears the bank, the holding register and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| esf_mode_i | input | 1 | 1 = extended-superframe, 0 = D4 |
| bit_vld_i | input | 1 | A stream bit is present this cycle |
| fbit_i | input | 1 | The present bit is the framing bit |
| frame_i | input | 5 | Frame number in the multiframe, 1-based |
| chan_i | input | 5 | Channel index 0..23 |
| bitpos_i | input | 3 | Bit index in the channel, 7 = LSB |
| ser_i | input | 1 | Incoming serial bit |
| wr_en_i | input | 1 | Bank write strobe |
| wr_chan_i | input | 5 | Channel whose nibble is written |
| wr_nib_i | input | 4 | Nibble value, bit 3 = first signaling bit |
| ser_o | output | 1 | Outgoing serial bit, one cycle delayed |
| vld_o | output | 1 | Delayed valid strobe |
| upd_irq_o | output | 1 | Update pulse after each load |

## Verification
The bench builds the block with its default of 24 channels, so the channel index is 5 bits wide. This leaves indices 24 to 31 free to drive as ignored writes without any aliasing. The bench runs full-length multiframes in both modes, switching extended-superframe, D4 and back. This shows the alternating D4 load cadence, the restart of that cadence after a mode change, and a write placed in the exact load cycle.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    localparam int FRAME_W  = 5;
    localparam int BITPOS_W = 3;
    localparam int NIB_W    = 4;
    localparam logic [BITPOS_W-1:0] LSB_POS = 3'd7;

    // nibble index of each signaling bit
    typedef enum logic [1:0] {
        SIG_D = 2'd0,
        SIG_C = 2'd1,
        SIG_B = 2'd2,
        SIG_A = 2'd3
    } sig_sel_e;

    typedef struct packed {
        logic                vld;
        logic                fbit;
        logic [FRAME_W-1:0]  frame;
        logic [BITPOS_W-1:0] bitpos;
        logic                data;
    } slot_t;

    function automatic logic is_sig_frame(input logic esf, input logic [FRAME_W-1:0] frame);
        logic hit;
        hit = (frame == 5'd6) || (frame == 5'd12);
        if (esf)
            hit = hit || (frame == 5'd18) || (frame == 5'd24);
        return hit;
    endfunction

    function automatic sig_sel_e sig_pick(input logic esf, input logic first_half,
                                          input logic [FRAME_W-1:0] frame);
        sig_sel_e s;
        if (esf) begin
            case (frame)
                5'd6:    s = SIG_A;
                5'd12:   s = SIG_B;
                5'd18:   s = SIG_C;
                default: s = SIG_D;
            endcase
        end else if (frame == 5'd6) begin
            s = first_half ? SIG_A : SIG_C;
        end else begin
            s = first_half ? SIG_B : SIG_D;
        end
        return s;
    endfunction

endpackage

// File: rtl/rbs_bank.sv
module rbs_bank
    import rbs_pkg::*;
#(
    parameter int NCH = 24,
    parameter int CW  = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en_i,
    input  logic [CW-1:0]               wr_chan_i,
    input  logic [NIB_W-1:0]            wr_nib_i,
    output logic [NCH-1:0][NIB_W-1:0]   bank_o
);

    logic [NCH-1:0][NIB_W-1:0] bank_q;
    logic                      in_range;

    assign in_range = (int'(wr_chan_i) < NCH);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_cell
            always_ff @(posedge clk) begin
                if (rst)
                    bank_q[c] <= '0;
                else if (wr_en_i && in_range && (int'(wr_chan_i) == c))
                    bank_q[c] <= wr_nib_i;
            end
        end
    endgenerate

    assign bank_o = bank_q;

    // R8
    oob_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (int'(wr_chan_i) >= NCH)) |=> $stable(bank_q));

endmodule

// File: rtl/rbs_hold.sv
module rbs_hold
    import rbs_pkg::*;
#(
    parameter int NCH = 24
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        esf_i,
    input  logic                        mf_start_i,
    input  logic [NCH-1:0][NIB_W-1:0]   bank_i,
    output logic [NCH-1:0][NIB_W-1:0]   hold_o,
    output logic                        first_half_o,
    output logic                        load_o
);

    logic [NCH-1:0][NIB_W-1:0] hold_q;
    logic                      half_q;
    logic                      load;

    // D4 loads only when half_q is clear; ESF loads at every start
    assign load = mf_start_i && (esf_i || !half_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            half_q <= 1'b0;
        end else begin
            if (load)
                hold_q <= bank_i;
            if (esf_i)
                half_q <= 1'b0;
            else if (mf_start_i)
                half_q <= ~half_q;
        end
    end

    assign hold_o       = hold_q;
    assign first_half_o = half_q;
    assign load_o       = load;

    // R6
    hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(hold_q));

    // R4
    load_copies_bank_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (hold_q == $past(bank_i)));

    // R4
    esf_clears_half_chk: assert property (@(posedge clk) disable iff (rst)
        esf_i |=> !half_q);

endmodule

// File: rtl/rbs_insert.sv
module rbs_insert
    import rbs_pkg::*;
#(
    parameter int NCH = 24,
    parameter int CW  = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        esf_i,
    input  logic                        first_half_i,
    input  slot_t                       slot_i,
    input  logic [CW-1:0]               chan_i,
    input  logic [NCH-1:0][NIB_W-1:0]   hold_i,
    output logic                        ser_o,
    output logic                        vld_o
);

    logic            rob;
    sig_sel_e        sel;
    logic [NIB_W-1:0] nib;
    logic            nxt;

    always_comb begin
        rob = slot_i.vld && !slot_i.fbit && (slot_i.bitpos == LSB_POS)
              && (int'(chan_i) < NCH) && is_sig_frame(esf_i, slot_i.frame);
        sel = sig_pick(esf_i, first_half_i, slot_i.frame);
        nib = (int'(chan_i) < NCH) ? hold_i[chan_i] : '0;
        if (!slot_i.vld)
            nxt = 1'b0;
        else if (rob)
            nxt = nib[sel];
        else
            nxt = slot_i.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_o <= 1'b0;
            vld_o <= 1'b0;
        end else begin
            ser_o <= nxt;
            vld_o <= slot_i.vld;
        end
    end

    // R2
    fbit_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_i.vld && slot_i.fbit) |=> (vld_o && (ser_o == $past(slot_i.data))));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_i.vld |=> (!vld_o && !ser_o));

endmodule

// File: rtl/rbs_tx_inserter.sv
module rbs_tx_inserter
    import rbs_pkg::*;
#(
    parameter int NCH = 24,
    localparam int CW = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 esf_mode_i,
    input  logic                 bit_vld_i,
    input  logic                 fbit_i,
    input  logic [FRAME_W-1:0]   frame_i,
    input  logic [CW-1:0]        chan_i,
    input  logic [BITPOS_W-1:0]  bitpos_i,
    input  logic                 ser_i,
    input  logic                 wr_en_i,
    input  logic [CW-1:0]        wr_chan_i,
    input  logic [NIB_W-1:0]     wr_nib_i,
    output logic                 ser_o,
    output logic                 vld_o,
    output logic                 upd_irq_o
);

    logic [NCH-1:0][NIB_W-1:0] bank;
    logic [NCH-1:0][NIB_W-1:0] hold;
    logic                      first_half;
    logic                      load;
    logic                      mf_start;
    slot_t                     slot;

    assign slot = '{vld: bit_vld_i, fbit: fbit_i, frame: frame_i,
                    bitpos: bitpos_i, data: ser_i};
    assign mf_start = bit_vld_i && fbit_i && (frame_i == 5'd1);

    rbs_bank #(.NCH(NCH), .CW(CW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_chan_i (wr_chan_i),
        .wr_nib_i  (wr_nib_i),
        .bank_o    (bank)
    );

    rbs_hold #(.NCH(NCH)) u_hold (
        .clk          (clk),
        .rst          (rst),
        .esf_i        (esf_mode_i),
        .mf_start_i   (mf_start),
        .bank_i       (bank),
        .hold_o       (hold),
        .first_half_o (first_half),
        .load_o       (load)
    );

    rbs_insert #(.NCH(NCH), .CW(CW)) u_ins (
        .clk          (clk),
        .rst          (rst),
        .esf_i        (esf_mode_i),
        .first_half_i (first_half),
        .slot_i       (slot),
        .chan_i       (chan_i),
        .hold_i       (hold),
        .ser_o        (ser_o),
        .vld_o        (vld_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            upd_irq_o <= 1'b0;
        else
            upd_irq_o <= load;
    end

    // R5
    irq_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        upd_irq_o |-> $past(mf_start));

endmodule

// File: tb/rbs_tx_inserter_tb.sv
module rbs_tx_inserter_tb;

    localparam int NCH = 24;

    logic       clk = 1'b0;
    logic       rst;
    logic       esf_mode_i, bit_vld_i, fbit_i, ser_i, wr_en_i;
    logic [4:0] frame_i, chan_i, wr_chan_i;
    logic [2:0] bitpos_i;
    logic [3:0] wr_nib_i;
    logic       ser_o, vld_o, upd_irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [3:0] bank_m [NCH];
    logic [3:0] hold_m [NCH];
    logic       half_m;
    int         tagged_chan;
    int         oob_loads;

    always #2.5 clk = ~clk;

    rbs_tx_inserter #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst), .esf_mode_i(esf_mode_i), .bit_vld_i(bit_vld_i),
        .fbit_i(fbit_i), .frame_i(frame_i), .chan_i(chan_i), .bitpos_i(bitpos_i),
        .ser_i(ser_i), .wr_en_i(wr_en_i), .wr_chan_i(wr_chan_i), .wr_nib_i(wr_nib_i),
        .ser_o(ser_o), .vld_o(vld_o), .upd_irq_o(upd_irq_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // expected signaling nibble index (3=first bit) from the requirements
    function automatic int exp_idx(input logic esf, input logic fh, input int fr);
        if (esf) return (fr == 6) ? 3 : (fr == 12) ? 2 : (fr == 18) ? 1 : 0;
        if (fr == 6) return fh ? 3 : 1;
        return fh ? 2 : 0;
    endfunction

    task automatic step(input logic esf, input logic v, input logic fb, input int fr,
                        input int ch, input int bp, input logic d,
                        input logic we, input int wc, input logic [3:0] wn);
        logic e_ser, e_irq, robbed, mfs, ld;
        string tag;
        @(negedge clk);
        esf_mode_i = esf; bit_vld_i = v; fbit_i = fb; frame_i = 5'(fr);
        chan_i = 5'(ch); bitpos_i = 3'(bp); ser_i = d;
        wr_en_i = we; wr_chan_i = 5'(wc); wr_nib_i = wn;
        robbed = v && !fb && bp == 7 && ch < NCH &&
                 ((fr == 6 || fr == 12) || (esf && (fr == 18 || fr == 24)));
        tag = "R2";
        if (!v) e_ser = 1'b0;
        else if (robbed) begin
            e_ser = hold_m[ch][exp_idx(esf, half_m, fr)];
            tag = esf ? "R1" : "R3";
            if (ch == tagged_chan) tag = "R7";
            else if (oob_loads > 0) tag = "R8";
            else if (bank_m[ch] != hold_m[ch]) tag = "R6";
        end else e_ser = d;
        mfs = v && fb && fr == 1;
        ld  = mfs && (esf || !half_m);
        e_irq = ld;
        if (ld) begin
            for (int c = 0; c < NCH; c++) hold_m[c] = bank_m[c];
            if (oob_loads > 0) oob_loads--;
        end
        if (esf) half_m = 1'b0;
        else if (mfs) half_m = ~half_m;
        if (we && wc < NCH) bank_m[wc] = wn;
        if (we && wc >= NCH) oob_loads = 2;
        @(posedge clk); #1;
        check(tag, ser_o, e_ser);
        check("R2", vld_o, v);
        check(esf ? "R5" : "R4", upd_irq_o, e_irq);
    endtask

    task automatic run_mf(input logic esf, input bit wr_at_load);
        int nfr = esf ? 24 : 12;
        for (int f = 1; f <= nfr; f++) begin
            logic we; int wc; logic [3:0] wn;
            we = 0; wc = 0; wn = 0;
            if (f == 1 && wr_at_load) begin
                // R7: write lands in the load cycle itself
                we = 1; wc = int'($urandom_range(0, NCH-1)); wn = 4'($urandom);
                tagged_chan = wc;
            end
            step(esf, 1, 1, f, 0, 0, 1'($urandom), we, wc, wn);
            for (int c = 0; c < NCH; c++)
                for (int b = 0; b < 8; b++) begin
                    we = ($urandom_range(0, 99) < 3);
                    wc = int'($urandom_range(0, 31));
                    wn = 4'($urandom);
                    if ($urandom_range(0, 49) == 0)
                        step(esf, 0, 0, f, c, b, 1'($urandom), 0, 0, 0);
                    step(esf, 1, 0, f, c, b, 1'($urandom), we, wc, wn);
                end
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        tagged_chan = -1; oob_loads = 0; half_m = 0;
        for (int c = 0; c < NCH; c++) begin bank_m[c] = 0; hold_m[c] = 0; end
        esf_mode_i = 1; bit_vld_i = 0; fbit_i = 0; frame_i = 0; chan_i = 0;
        bitpos_i = 0; ser_i = 0; wr_en_i = 0; wr_chan_i = 0; wr_nib_i = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        check("R9", ser_o, 1'b0);
        check("R9", vld_o, 1'b0);
        check("R9", upd_irq_o, 1'b0);
        @(negedge clk); rst = 0;
        // preload every channel, then stream
        for (int c = 0; c < NCH; c++)
            step(1, 0, 0, 0, 0, 0, 0, 1, c, 4'($urandom));
        step(1, 0, 0, 0, 0, 0, 0, 1, 27, 4'hF);   // R8 out-of-range write
        run_mf(1, 0);
        run_mf(1, 1);
        run_mf(1, 0);
        tagged_chan = -1;
        for (int m = 0; m < 6; m++) run_mf(0, m == 2);   // R3 R4 D4 cadence
        tagged_chan = -1;
        run_mf(1, 0);
        run_mf(0, 0);                                    // R4 restart after ESF
        run_mf(0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule